// File: doc/BRIEF.md
# Run-Time Configurable I/Q Decimation Cascade

This block lowers the sample rate of a complex baseband stream. Signed 16-bit in-phase and quadrature words arrive with a valid strobe. They pass through a fixed cascade of small-ratio stages. The head stage divides by ten. It is followed by five stages that each divide by two. A configuration word enables or bypasses each stage on its own. The overall ratio is therefore the product of the enabled ratios. Enabling all five halving stages gives 32 and enabling three gives 8. Enabling the head stage together with two halving stages gives 40.

An enabled stage of ratio N adds N consecutive accepted samples. Once per group it emits the scaled sum, saturated to 16 bits. A bypassed stage registers each sample straight through, so every stage costs exactly one cycle. I and Q share one valid strobe and one phase counter per stage, so the two outputs always belong to the same instant.

A two-state controller guards reconfiguration:
- FLUSH is entered from reset. It clears every accumulator and phase counter, and it latches the requested configuration.
- FLUSH always moves to RUN on the next cycle.
- RUN accepts input samples. It returns to FLUSH whenever the requested configuration differs from the applied one.

Top module: `iq_decim_chain`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_vld is 0 and out_i and out_q are 0.
- R2: Bit 0 of cfg_en enables the head divide-by-10 stage, and bits 1 to 5 each enable one divide-by-2 stage; the overall ratio is (bit0 ? 10 : 1) times 2 to the power of the number of set bits among 1 to 5.
- R3: An enabled divide-by-2 stage outputs floor((a+b)/2) of each pair of accepted samples, separately for I and Q.
- R4: The enabled divide-by-10 stage outputs floor(S*6554/65536), where S is the sum of ten accepted samples.
- R5: With every stage bypassed, each accepted sample appears unchanged on the output exactly 6 cycles after the cycle in which it was presented.
- R6: With ratio R, exactly one output is produced per R accepted inputs. Gaps in in_vld do not change the values. For any nonzero configuration, out_vld is never high on two consecutive cycles.
- R7: A change of cfg_en causes one FLUSH cycle that discards partly collected groups. Samples presented while the requested and applied configuration differ are dropped. out_vld is low on the cycle after FLUSH, and the first new output needs a full group collected after the change.
- R8: out_i and out_q change only on cycles where out_vld is high, and both belong to the same input group.
- R9: Results outside the signed 16-bit range saturate to 32767 or -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 6 | Stage enables (bit 0 head divide-by-10, bits 1-5 divide-by-2) |
| in_vld | input | 1 | Input sample valid |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| out_vld | output | 1 | Output sample valid |
| out_i | output | 16 | Output in-phase sample, signed |
| out_q | output | 16 | Output quadrature sample, signed |

## Verification
Each of the ratios 32, 8 and 40 is fed a stream with irregular valid gaps. A design that miscounts phases or stalls on gaps would then give the wrong number of outputs, or sums taken over the wrong samples. Full-scale positive and negative groups drive the divide-by-10 reciprocal past the 16-bit range; missing saturation would wrap to the opposite sign. A configuration change in the middle of a group checks that the leftover partial sums are discarded rather than mixed into the first output of the new ratio. The all-bypass run timestamps each sample, so a missing or extra pipeline register shows up as a latency error.

// File: rtl/iq_decim_pkg.sv
package iq_decim_pkg;

    localparam int SAMP_W = 16;

    typedef struct packed {
        logic                     vld;
        logic signed [SAMP_W-1:0] i;
        logic signed [SAMP_W-1:0] q;
    } iq_t;

    typedef enum logic {
        ST_FLUSH = 1'b0,
        ST_RUN   = 1'b1
    } ctl_state_t;

endpackage

// File: rtl/iq_decim_stage.sv
module iq_decim_stage
    import iq_decim_pkg::*;
#(
    parameter int RATIO      = 2,
    parameter int RECIP_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  iq_t  s_in,
    output iq_t  s_out
);
    localparam int     SH     = $clog2(RATIO);
    localparam int     SUM_W  = SAMP_W + SH;
    localparam int     PROD_W = SUM_W + RECIP_BITS + 2;
    localparam bit     POW2   = (RATIO & (RATIO - 1)) == 0;
    localparam longint RECIP  = ((longint'(1) << RECIP_BITS) + RATIO - 1) / RATIO;
    localparam logic signed [PROD_W-1:0] HI = PROD_W'((longint'(1) << (SAMP_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] LO = PROD_W'(-(longint'(1) << (SAMP_W - 1)));

    logic [SH-1:0]            phase;
    logic signed [SUM_W-1:0]  acc_i, acc_q;
    logic signed [SUM_W-1:0]  nxt_i, nxt_q;
    logic                     grp_done;

    function automatic logic signed [SAMP_W-1:0] shrink(input logic signed [SUM_W-1:0] s);
        logic signed [PROD_W-1:0] w;
        if (POW2) begin
            w = PROD_W'(s) >>> SH;
        end else begin
            w = (PROD_W'(s) * PROD_W'(RECIP)) >>> RECIP_BITS;
        end
        if (w > HI) begin
            return SAMP_W'(HI);
        end else if (w < LO) begin
            return SAMP_W'(LO);
        end
        return SAMP_W'(w);
    endfunction

    always_comb begin
        nxt_i    = acc_i + SUM_W'(s_in.i);
        nxt_q    = acc_q + SUM_W'(s_in.q);
        grp_done = (phase == SH'(RATIO - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            acc_i <= '0;
            acc_q <= '0;
            s_out <= '0;
        end else if (clr) begin
            phase     <= '0;
            acc_i     <= '0;
            acc_q     <= '0;
            s_out.vld <= 1'b0;
        end else begin
            s_out.vld <= 1'b0;
            if (s_in.vld) begin
                if (!en) begin
                    s_out <= s_in;
                end else if (grp_done) begin
                    s_out.vld <= 1'b1;
                    s_out.i   <= shrink(nxt_i);
                    s_out.q   <= shrink(nxt_q);
                    phase     <= '0;
                    acc_i     <= '0;
                    acc_q     <= '0;
                end else begin
                    acc_i <= nxt_i;
                    acc_q <= nxt_q;
                    phase <= phase + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/iq_decim_chain.sv
module iq_decim_chain
    import iq_decim_pkg::*;
#(
    parameter int HALF_STAGES = 5,
    parameter int HEAD_RATIO  = 10,
    parameter int RECIP_BITS  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [HALF_STAGES:0]     cfg_en,
    input  logic                     in_vld,
    input  logic signed [SAMP_W-1:0] in_i,
    input  logic signed [SAMP_W-1:0] in_q,
    output logic                     out_vld,
    output logic signed [SAMP_W-1:0] out_i,
    output logic signed [SAMP_W-1:0] out_q
);
    localparam int NSTAGE = HALF_STAGES + 1;

    ctl_state_t          state, state_nxt;
    logic [NSTAGE-1:0]   cfg_q;
    logic                clr;
    logic                accept;
    iq_t                 chain [NSTAGE+1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FLUSH;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FLUSH: state_nxt = ST_RUN;
            ST_RUN:   if (cfg_en != cfg_q) state_nxt = ST_FLUSH;
        endcase
    end

    // state outputs
    always_comb begin
        clr    = 1'b0;
        accept = 1'b0;
        unique case (state)
            ST_FLUSH: clr    = 1'b1;
            ST_RUN:   accept = in_vld && (cfg_en == cfg_q);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (state == ST_FLUSH) begin
            cfg_q <= cfg_en;
        end
    end

    always_comb begin
        chain[0].vld = accept;
        chain[0].i   = in_i;
        chain[0].q   = in_q;
    end

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        iq_decim_stage #(
            .RATIO      ((g == 0) ? HEAD_RATIO : 2),
            .RECIP_BITS (RECIP_BITS)
        ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .en    (cfg_q[g]),
            .s_in  (chain[g]),
            .s_out (chain[g+1])
        );
    end

    always_comb begin
        out_vld = chain[NSTAGE].vld;
        out_i   = chain[NSTAGE].i;
        out_q   = chain[NSTAGE].q;
    end

endmodule

// File: rtl/iq_decim_chk.sv
module iq_decim_chk
    import iq_decim_pkg::*;
#(
    parameter int CFG_W = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [CFG_W-1:0]         cfg_en,
    input logic [CFG_W-1:0]         cfg_q,
    input ctl_state_t               state,
    input logic                     out_vld,
    input logic signed [SAMP_W-1:0] out_i,
    input logic signed [SAMP_W-1:0] out_q
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && out_i == '0 && out_q == '0));

    assert_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && cfg_q != '0) |=> !out_vld);

    assert_flush_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cfg_en != cfg_q) |=> state == ST_FLUSH);

    assert_quiet_after_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |=> !out_vld);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> ($stable(out_i) && $stable(out_q)));

endmodule

bind iq_decim_chain iq_decim_chk #(.CFG_W(HALF_STAGES + 1)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_q   (cfg_q),
    .state   (state),
    .out_vld (out_vld),
    .out_i   (out_i),
    .out_q   (out_q)
);

// File: tb/sim_iq_decim_chain.sv
module sim_iq_decim_chain;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [5:0]         cfg_en = '0;
    logic               in_vld = 1'b0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic               out_vld;
    logic signed [15:0] out_i, out_q;

    typedef struct {
        int    ei;
        int    eq;
        int    ecyc;
        string req;
    } exp_t;

    exp_t       sb[$];
    int         total = 0, bad = 0, cyc = 0, n_out = 0;
    int         acc_i[6], acc_q[6], ph[6];
    logic [5:0] mcfg = '0;
    string      cur_req = "R1";
    bit         done = 0;

    iq_decim_chain u0 (.*);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int scale(input int a, input int s);
        longint p;
        if (s == 0) begin
            p = longint'(a) * 6554;
            p = p >>> 16;
        end else begin
            p = longint'(a) >>> 1;
        end
        return sat16(p);
    endfunction

    task automatic model_reset(input logic [5:0] c);
        mcfg = c;
        for (int s = 0; s < 6; s++) begin
            acc_i[s] = 0; acc_q[s] = 0; ph[s] = 0;
        end
    endtask

    task automatic model_feed(input int xi, input int xq, input int ecyc);
        int vi = xi, vq = xq;
        exp_t e;
        for (int s = 0; s < 6; s++) begin
            if (mcfg[s]) begin
                acc_i[s] += vi; acc_q[s] += vq; ph[s]++;
                if (ph[s] < ((s == 0) ? 10 : 2)) return;
                vi = scale(acc_i[s], s); vq = scale(acc_q[s], s);
                acc_i[s] = 0; acc_q[s] = 0; ph[s] = 0;
            end
        end
        e.ei = vi; e.eq = vq; e.ecyc = (mcfg == 0) ? ecyc : -1; e.req = cur_req;
        sb.push_back(e);
    endtask

    // driver: called just after a falling edge, returns just after the next one
    task automatic send(input int xi, input int xq, input bit to_model);
        in_vld = 1'b1; in_i = 16'(xi); in_q = 16'(xq);
        if (to_model) model_feed(xi, xq, cyc + 6);
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [5:0] c);
        cfg_en = c;
        idle(3);
        model_reset(c);
    endtask

    task automatic stream(input int n, input int seed, input int gap_every);
        for (int k = 0; k < n; k++) begin
            send(((k * 3797 + seed) % 65536) - 32768, ((k * 9161 + seed * 7) % 65536) - 32768, 1'b1);
            if (gap_every != 0 && (k % gap_every) == 0) idle(1 + (k % 2));
        end
    endtask

    task automatic expect_count(input int base, input int want, input string req);
        idle(20);
        chk(sb.size() == 0, req, sb.size(), 0);
        chk(n_out - base == want, req, n_out - base, want);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            exp_t e;
            n_out++;
            if (sb.size() == 0) begin
                chk(1'b0, "R7 unexpected output", int'(out_i), 0);
            end else begin
                e = sb.pop_front();
                chk(int'(out_i) == e.ei, {e.req, " I value"}, int'(out_i), e.ei);
                chk(int'(out_q) == e.eq, {e.req, " Q value"}, int'(out_q), e.eq);
                if (e.ecyc >= 0)
                    chk(cyc == e.ecyc, {e.req, " latency cycle"}, cyc, e.ecyc);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        logic signed [15:0] held;
        idle(3);
        chk(out_vld == 1'b0, "R1 vld", int'(out_vld), 0);
        chk(out_i == 0 && out_q == 0, "R1 data", int'(out_i), 0);
        rst_n = 1'b1;
        idle(1);
        chk(out_vld == 1'b0 && out_i == 0, "R1 after release", int'(out_i), 0);
        model_reset(6'b000000);
        idle(3);

        // R5, R2: all bypassed, 6-cycle latency
        cur_req = "R5"; base = n_out;
        for (int k = 0; k < 8; k++) send(k * 1000 - 4000, 7 - k * 911, 1'b1);
        expect_count(base, 8, "R5 count");

        // R6, R3: ratio 32 with gaps
        cur_req = "R6 ratio32 R3"; set_cfg(6'b111110); base = n_out;
        stream(96, 11, 3);
        expect_count(base, 3, "R6 ratio32 count");
        held = out_i; idle(5);
        chk(out_i == held, "R8 hold", int'(out_i), int'(held));

        // R6, R2: ratio 8
        cur_req = "R6 ratio8"; set_cfg(6'b001110); base = n_out;
        stream(40, 502, 4);
        expect_count(base, 5, "R6 ratio8 count");

        // R4, R2: ratio 40 = 10 x 2 x 2
        cur_req = "R4 ratio40"; set_cfg(6'b000111); base = n_out;
        stream(120, 77, 5);
        expect_count(base, 3, "R4 ratio40 count");

        // R9: divide-by-10 saturation both ways
        cur_req = "R9 saturation"; set_cfg(6'b000001); base = n_out;
        for (int k = 0; k < 10; k++) send(-32768, 32767, 1'b1);
        for (int k = 0; k < 10; k++) send(32767, -32768, 1'b1);
        expect_count(base, 2, "R9 count");

        // R7: partial group discarded on reconfiguration
        cur_req = "R7 reconfig"; set_cfg(6'b001110); base = n_out;
        for (int k = 0; k < 5; k++) send(30000, -30000, 1'b1);
        cfg_en = 6'b000010;
        send(12345, 12345, 1'b0);
        idle(3);
        model_reset(6'b000010);
        send(100, -3, 1'b1); send(301, 8, 1'b1);
        send(-7, -7, 1'b1);  send(-8, 2, 1'b1);
        expect_count(base, 2, "R7 count");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule